// File: doc/BRIEF.md
# Centre-Aligned PWM Timer

This block is an 8-bit timer whose count climbs from zero to its ceiling and then falls back to zero, so it traces a triangle. It advances only on a clock-enable tick from a programmable divider, so the timer runs in the system clock domain. An active compare value is tested against the count on each step. On the rising slope a match drives the waveform one way, and on the falling slope the same match drives it the other way. The pulses stay centred on the bottom of the triangle, and the duty cycle depends only on the compare value.

Software uses a four-entry register window. It writes a staged compare value, which becomes active only when the count reaches its ceiling. It writes a control byte that picks the divider and the output polarity. It reads and clears two sticky event flags, and it can read the live count. Both flags also drive interrupt-request outputs.

Top module: `pcpwm_timer`

## Requirements
- R1: With divide-by-1 selected, the count goes 0,1,…,255,254,…,1,0 and repeats. One full cycle is 510 ticks, and the count changes by exactly one per tick.
- R2: Control bits [2:0] select the divider: 1→1, 2→8, 3→32, 4→64, 5→128, 6→256, 7→1024. Value 0 freezes the count. With value 2, the waveform period is 4080 clocks.
- R3: Flag bit 0 (overflow, register address 2) sets after the count steps down to 0. The ovf_irq_o output mirrors it.
- R4: Control bits [5:4] = 2 selects normal polarity. The output goes low on a match while climbing and high on a match while falling, so with compare value C it is high for 2·C ticks of every 510.
- R5: Control bits [5:4] = 3 selects inverted polarity. The output is the complement of R4, which gives 510−2·C high ticks with divide-by-1.
- R6: A compare value of 0 holds the output constantly low under normal polarity, and 255 holds it constantly high. Inverted polarity gives the opposite levels.
- R7: A write to address 0 stages the compare value. The staged value is applied only when the count reaches 255, so a mid-ramp write does not change the current rising slope.
- R8: Control bits [5:4] = 0 or 1 disconnect the waveform, and pwm_o stays low.
- R9: Flag bit 1 (compare match) sets when a count step lands on the active compare value. cmp_irq_o mirrors it.
- R10: Writing 1 to a flag bit at address 2 clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R11: After reset the count is 0, both flags are 0, pwm_o is low and the control byte is 0, so the timer is stopped.
- R12: Addresses 0 and 1 read back the staged compare value and the full control byte. Address 3 reads the live count. Reads are combinational from bus_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 compare, 1 control, 2 flags, 3 count) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| pwm_o | output | 1 | Waveform output |
| ovf_irq_o | output | 1 | Overflow flag level |
| cmp_irq_o | output | 1 | Compare-match flag level |

## Verification
The bench probes the compare values 0 and 255. A design that used only the match rule at these values would emit a one-tick spike every period, where a flat level is required. It then writes a new compare value halfway up a ramp and samples the output on both slopes. A design that applied the value at once would stay high past the old match, and one that never reloaded would miss the set point on the way down. It also lands a flag clear on the very cycle the count reaches 0: a design where the clear wins would lose the overflow event. Duty and period are totalled over whole periods at divide-by-1 and divide-by-8, which exposes off-by-one turn-around points.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
  localparam int PRE_W = 10;
  localparam int NFLAG = 2;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMP = 1;

  typedef enum logic [1:0] {
    REG_CMP  = 2'd0,
    REG_CTRL = 2'd1,
    REG_FLAG = 2'd2,
    REG_CNT  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    OUT_OFF_A = 2'd0,
    OUT_OFF_B = 2'd1,
    OUT_NORM  = 2'd2,
    OUT_INV   = 2'd3
  } out_mode_e;

  // divider select -> terminal count (N-1)
  function automatic logic [PRE_W-1:0] presc_limit(input logic [2:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      3'd2:    lim = PRE_W'(7);
      3'd3:    lim = PRE_W'(31);
      3'd4:    lim = PRE_W'(63);
      3'd5:    lim = PRE_W'(127);
      3'd6:    lim = PRE_W'(255);
      3'd7:    lim = PRE_W'(1023);
      default: lim = '0;
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
  import pcpwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;
  logic             run;

  assign lim    = presc_limit(sel_i);
  assign run    = (sel_i != 3'd0);
  assign tick_o = run && (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (!run || tick_o)  div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pcpwm_updown_counter.sv
module pcpwm_updown_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o,
  output logic             step_up_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             up_q, step_q, step_up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      up_q      <= 1'b1;
      step_q    <= 1'b0;
      step_up_q <= 1'b0;
    end else begin
      step_q <= tick_i;
      if (tick_i) begin
        step_up_q <= up_q;
        if (up_q) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == TOP - 1'b1) up_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) up_q <= 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign step_o    = step_q;
  assign step_up_o = step_up_q;
endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             step_up_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ocr_buf_i,
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] ocr_act_o,
  output logic             wave_o,
  output logic             cmp_hit_o,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] ocr_act_q;
  logic             wave_q;

  // staged compare becomes active at the ceiling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ocr_act_q <= '0;
    else if (step_i && cnt_i == TOP) ocr_act_q <= ocr_buf_i;
  end

  // wave_q holds the normal-polarity level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else if (step_i) begin
      if (ocr_act_q == '0)           wave_q <= 1'b0;
      else if (ocr_act_q == TOP)     wave_q <= 1'b1;
      else if (cnt_i == ocr_act_q)   wave_q <= ~step_up_i;
    end
  end

  assign cmp_hit_o = step_i && (cnt_i == ocr_act_q);
  assign ocr_act_o = ocr_act_q;
  assign wave_o    = wave_q;
  assign pwm_o     = mode_i[1] & (wave_q ^ mode_i[0]);
endmodule

// File: rtl/pcpwm_regs.sv
module pcpwm_regs
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [NFLAG-1:0] flag_set_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [CNT_W-1:0] ocr_buf_o,
  output logic [2:0]       sel_o,
  output logic [1:0]       mode_o,
  output logic [NFLAG-1:0] flag_o
);
  logic [CNT_W-1:0] ocr_buf_q, ctrl_q;
  logic [NFLAG-1:0] flag_q, flag_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_buf_q <= '0;
      ctrl_q    <= '0;
    end else if (we_i) begin
      if (addr_i == REG_CMP)  ocr_buf_q <= wdata_i;
      if (addr_i == REG_CTRL) ctrl_q    <= wdata_i;
    end
  end

  assign flag_clr = (we_i && addr_i == REG_FLAG) ? wdata_i[NFLAG-1:0] : '0;

  // set wins over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else begin
      for (int i = 0; i < NFLAG; i++) begin
        if (flag_set_i[i])    flag_q[i] <= 1'b1;
        else if (flag_clr[i]) flag_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      REG_CMP:  rdata_o = ocr_buf_q;
      REG_CTRL: rdata_o = ctrl_q;
      REG_FLAG: rdata_o = CNT_W'(flag_q);
      default:  rdata_o = cnt_i;
    endcase
  end

  assign ocr_buf_o = ocr_buf_q;
  assign sel_o     = ctrl_q[2:0];
  assign mode_o    = ctrl_q[5:4];
  assign flag_o    = flag_q;
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             pwm_o,
  output logic             ovf_irq_o,
  output logic             cmp_irq_o
);
  logic             tick, step, step_up, cmp_hit, wave;
  logic [CNT_W-1:0] cnt, ocr_buf, ocr_act;
  logic [2:0]       sel;
  logic [1:0]       mode;
  logic [NFLAG-1:0] flag_set, flags;

  pcpwm_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .tick_o (tick)
  );

  pcpwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cnt_o     (cnt),
    .step_o    (step),
    .step_up_o (step_up)
  );

  pcpwm_wavegen #(.CNT_W(CNT_W)) u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .step_up_i (step_up),
    .cnt_i     (cnt),
    .ocr_buf_i (ocr_buf),
    .mode_i    (mode),
    .ocr_act_o (ocr_act),
    .wave_o    (wave),
    .cmp_hit_o (cmp_hit),
    .pwm_o     (pwm_o)
  );

  assign flag_set[FLAG_OVF] = step && (cnt == '0);
  assign flag_set[FLAG_CMP] = cmp_hit;

  pcpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .cnt_i      (cnt),
    .flag_set_i (flag_set),
    .rdata_o    (bus_rdata_o),
    .ocr_buf_o  (ocr_buf),
    .sel_o      (sel),
    .mode_o     (mode),
    .flag_o     (flags)
  );

  assign ovf_irq_o = flags[FLAG_OVF];
  assign cmp_irq_o = flags[FLAG_CMP];
endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             step_i,
  input logic [2:0]       sel_i,
  input logic [CNT_W-1:0] ocr_act_i,
  input logic             wave_i,
  input logic             ovf_i
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_cnt_unit_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> ((cnt_i == $past(cnt_i) + 1'b1) || (cnt_i == $past(cnt_i) - 1'b1)));

  assert_frozen_when_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0) |=> $stable(cnt_i));

  assert_ovf_after_bottom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_i == '0) |=> ovf_i);

  assert_wave_on_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_i != $past(wave_i)) |-> $past(step_i));

  assert_empty_duty_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && ocr_act_i == '0) |=> !wave_i);

  assert_load_at_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocr_act_i != $past(ocr_act_i)) |-> ($past(cnt_i) == TOP));
endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (cnt),
  .step_i    (step),
  .sel_i     (sel),
  .ocr_act_i (ocr_act),
  .wave_i    (wave),
  .ovf_i     (flags[0])
);

// File: tb/pcpwm_timer_tb.sv
`timescale 1ns/1ps
module pcpwm_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic [7:0] bus_rdata_o;
  logic       pwm_o, ovf_irq_o, cmp_irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { string tag; int exp; } sb_item_t;
  sb_item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  pcpwm_timer dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pwm_o       (pwm_o),
    .ovf_irq_o   (ovf_irq_o),
    .cmp_irq_o   (cmp_irq_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver side: expected results into the scoreboard
  task automatic push_exp(input string tag, input int exp);
    sb_item_t it;
    it.tag = tag;
    it.exp = exp;
    sb_q.push_back(it);
  endtask

  // monitor side: pop and compare against a measured result
  task automatic sb_compare(input int act);
    sb_item_t it;
    if (sb_q.size() == 0) begin
      check("SB_EMPTY", 1, 0);
    end else begin
      it = sb_q.pop_front();
      check(it.tag, act, it.exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_we_i    = 1'b1;
    bus_addr_i  = a;
    bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i    = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output int v);
    bus_addr_i = a;
    #1;
    v = int'(bus_rdata_o);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic monitor_high(input int period);
    int hi = 0;
    for (int i = 0; i < period; i++) begin
      @(negedge clk_i);
      if (pwm_o) hi++;
    end
    sb_compare(hi);
  endtask

  task automatic monitor_ovf_period();
    int n;
    bus_write(2'd2, 8'h01);
    while (!ovf_irq_o) @(negedge clk_i);
    bus_write(2'd2, 8'h01);
    n = 1;
    while (!ovf_irq_o) begin
      @(negedge clk_i);
      n++;
    end
    sb_compare(n);
  endtask

  task automatic wait_pass(input int from_v, input int to_v);
    int prev = -1;
    int cur;
    forever begin
      @(negedge clk_i);
      bus_read(2'd3, cur);
      if (prev == from_v && cur == to_v) break;
      prev = cur;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(negedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL WATCHDOG actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R11 reset state
    check("R11 pwm", int'(pwm_o), 0);
    bus_read(2'd3, v); check("R11 count", v, 0);
    bus_read(2'd2, v); check("R11 flags", v, 0);
    bus_read(2'd1, v); check("R11 ctrl", v, 0);
    @(negedge clk_i);

    // R12 readback, then normal polarity divide-by-1
    bus_write(2'd0, 8'd100);
    bus_write(2'd1, 8'h21);
    bus_read(2'd0, v); check("R12 cmp readback", v, 100);
    bus_read(2'd1, v); check("R12 ctrl readback", v, 8'h21);
    @(negedge clk_i);
    idle(1100);
    push_exp("R4 high ticks C=100", 200);
    monitor_high(510);

    push_exp("R1 period div1", 510);
    monitor_ovf_period();

    // R3 / R9 flags set within a period
    bus_write(2'd2, 8'h03);
    idle(600);
    check("R3 ovf flag", int'(ovf_irq_o), 1);
    check("R9 cmp flag", int'(cmp_irq_o), 1);

    // R10 with the timer stopped
    bus_write(2'd1, 8'h20);
    idle(2);
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, v); check("R10 write0 keeps", v, 3);
    @(negedge clk_i);
    bus_write(2'd2, 8'h01);
    bus_read(2'd2, v); check("R10 w1c bit0", v, 2);
    @(negedge clk_i);
    bus_write(2'd1, 8'h21);
    wait_pass(1, 0);
    bus_write(2'd2, 8'h01);
    check("R10 set beats clear", int'(ovf_irq_o), 1);
    bus_write(2'd2, 8'h01);
    check("R10 clear", int'(ovf_irq_o), 0);

    // R5 inverted polarity
    bus_write(2'd1, 8'h31);
    idle(1100);
    push_exp("R5 inverted C=100", 310);
    monitor_high(510);

    // R6 extremes
    bus_write(2'd0, 8'd0);
    bus_write(2'd1, 8'h21);
    idle(1100);
    push_exp("R6 C=0 normal", 0);
    monitor_high(510);
    bus_write(2'd1, 8'h31);
    idle(20);
    push_exp("R6 C=0 inverted", 510);
    monitor_high(510);
    bus_write(2'd0, 8'd255);
    bus_write(2'd1, 8'h21);
    idle(1100);
    push_exp("R6 C=255 normal", 510);
    monitor_high(510);
    bus_write(2'd1, 8'h31);
    idle(20);
    push_exp("R6 C=255 inverted", 0);
    monitor_high(510);

    // R8 disconnected modes
    bus_write(2'd0, 8'd100);
    bus_write(2'd1, 8'h11);
    idle(1100);
    push_exp("R8 mode1", 0);
    monitor_high(510);
    bus_write(2'd1, 8'h01);
    push_exp("R8 mode0", 0);
    monitor_high(510);

    // R7 staged compare
    bus_write(2'd1, 8'h21);
    idle(1100);
    wait_pass(49, 50);
    bus_write(2'd0, 8'd200);
    wait_pass(149, 150);
    check("R7 old value on rising slope", int'(pwm_o), 0);
    wait_pass(151, 150);
    check("R7 new value on falling slope", int'(pwm_o), 1);

    // R2 divide-by-8 and stop
    bus_write(2'd0, 8'd100);
    bus_write(2'd1, 8'h22);
    idle(8200);
    push_exp("R2 high ticks div8", 1600);
    monitor_high(4080);
    push_exp("R2 period div8", 4080);
    monitor_ovf_period();
    bus_write(2'd1, 8'h20);
    idle(2);
    begin
      int a, b;
      bus_read(2'd3, a);
      idle(50);
      bus_read(2'd3, b);
      check("R2 stopped count stable", b, a);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule